// File: doc/BRIEF.md
# Switchable-Bank Cartridge Latch Mapper

This block is the single 8-bit bank register of a simple cartridge mapper for an 8-bit CPU. The CPU sees a 32 KiB window at 0x8000–0xFFFF. The lower 16 KiB of that window can be switched to any of 32 program banks in a 512 KiB program memory. The upper 16 KiB always shows the last bank. The same register also supplies the bank bits for a banked character RAM and picks which of two single-screen nametables the video side uses.

Two write modes are supported, chosen by a static configuration input. With flash saving off, every write into the window loads the register. The program memory drives the data bus at the same time, so the value stored is the CPU byte ANDed with the memory byte at that address. With flash saving on, writes into the switchable half go only to a flash command port and leave the register alone. Writes into the fixed half load the register with the CPU byte, unmodified. The flash command address is formed from the CPU offset bits, with register bit 0 placed above them.

The flash command decoder and the memories sit outside this block. The program-memory read byte is an input, used only for the bus-conflict AND.

Top module: `bank_latch_mapper`

## Requirements
- R1: While reset is active, and after it is released, the register holds 0x00 until the first qualifying write.
- R2: For a CPU address with bits 15:14 = 10, `prg_addr` equals register bits 4:0 followed by CPU address bits 13:0, with the bank number in `prg_addr[18:14]`.
- R3: For a CPU address with bits 15:14 = 11, `prg_addr` equals 5'b11111 followed by CPU address bits 13:0.
- R4: `chr_bank` is register bits 6:5, ANDed with a mask selected by `chr_size_sel`:
  - 0 selects 8 KiB, and both bits are forced to 0.
  - 1 selects 16 KiB, and bit 1 is forced to 0.
  - 2 or 3 selects 32 KiB, and both bits pass.
- R5: `mirror_sel` equals register bit 7 at all times.
- R6: With `flash_save_en` low, a write to any address with bit 15 set loads `cpu_wdata & prg_rdata`. The new value is visible on the outputs after the next rising clock edge.
- R7: With `flash_save_en` high, a write to an address with bits 15:14 = 11 loads `cpu_wdata` unchanged, whatever `prg_rdata` holds.
- R8: With `flash_save_en` high, a write to an address with bits 15:14 = 10 leaves the register unchanged. In the same cycle it raises `flash_cmd_we`, with:
  - `flash_cmd_data` = `cpu_wdata`;
  - `flash_cmd_addr` = register bit 0 at bit 14 and CPU address bits 13:0 below it.
- R9: A write with CPU address bit 15 clear changes nothing: the register keeps its value and `flash_cmd_we` stays low.
- R10: `flash_cmd_we` is never high while `flash_save_en` is low, nor while `cpu_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Write strobe, one cycle per CPU write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| prg_rdata | input | 8 | Program-memory byte at the addressed location, used for the bus-conflict AND |
| flash_save_en | input | 1 | Static mode: 1 routes lower-half writes to flash, 0 enables bus conflicts |
| chr_size_sel | input | 2 | Character-RAM size: 0 = 8 KiB, 1 = 16 KiB, 2/3 = 32 KiB |
| prg_addr | output | 19 | Program-memory byte address |
| chr_bank | output | 2 | Character-RAM 8 KiB bank select |
| mirror_sel | output | 1 | Single-screen nametable select |
| flash_cmd_we | output | 1 | Flash command write strobe |
| flash_cmd_addr | output | 15 | Flash command address |
| flash_cmd_data | output | 8 | Flash command data |

## Verification
The assertions assume two things about the inputs:
- `flash_save_en` and `chr_size_sel` are configuration that is stable around every write;
- `prg_rdata` is already valid during the strobe cycle, so the AND result can be compared one cycle later against the sampled inputs.

The stimulus changes the mode only while `cpu_wr` is low. It drives each write for exactly one cycle with `prg_rdata` held beside it. Random addresses cover all four quadrants of the 16-bit space, so that ignored low-half writes occur alongside both window halves.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  parameter int BANK_W = 5;
  parameter int CHR_W  = 2;
  parameter int OFS_W  = 14;
  localparam int REG_W  = BANK_W + CHR_W + 1;
  localparam int PRG_AW = BANK_W + OFS_W;
  localparam int FLS_AW = OFS_W + 1;

  // bit 7 mirror, bits 6:5 character bank, bits 4:0 program bank
  typedef struct packed {
    logic              mirror;
    logic [CHR_W-1:0]  chr;
    logic [BANK_W-1:0] bank;
  } latch_t;

  function automatic logic [PRG_AW-1:0] prg_map(input logic [BANK_W-1:0] bank,
                                               input logic upper,
                                               input logic [OFS_W-1:0] ofs);
    logic [BANK_W-1:0] b;
    b = upper ? {BANK_W{1'b1}} : bank;
    return {b, ofs};
  endfunction

  // bit i of the character bank survives when i < size code
  function automatic logic [CHR_W-1:0] chr_mask(input logic [1:0] sel);
    logic [CHR_W-1:0] m;
    for (int i = 0; i < CHR_W; i++) m[i] = (i < int'(sel));
    return m;
  endfunction

  function automatic logic [REG_W-1:0] conflict(input logic [REG_W-1:0] d,
                                               input logic [REG_W-1:0] r,
                                               input logic en);
    return en ? (d & r) : d;
  endfunction
endpackage

// File: rtl/latch_reg.sv
module latch_reg
  import mapper_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  latch_t d,
  output latch_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/write_decode.sv
module write_decode
  import mapper_pkg::*;
(
  input  logic             cpu_wr,
  input  logic [1:0]       addr_hi,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] rdata,
  input  logic             flash_save_en,
  output logic             load,
  output logic             flash_we,
  output latch_t           next_val
);
  logic in_window, in_lower;
  always_comb begin
    in_window = addr_hi[1];
    in_lower  = in_window && !addr_hi[0];
    flash_we  = cpu_wr && flash_save_en && in_lower;
    load      = cpu_wr && in_window && !(flash_save_en && in_lower);
    next_val  = latch_t'(conflict(wdata, rdata, !flash_save_en));
  end
endmodule

// File: rtl/prg_decode.sv
module prg_decode
  import mapper_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W:0]    addr,
  output logic [PRG_AW-1:0] prg_addr
);
  assign prg_addr = prg_map(bank, addr[OFS_W], addr[OFS_W-1:0]);
endmodule

// File: rtl/chr_mirror.sv
module chr_mirror
  import mapper_pkg::*;
(
  input  logic [CHR_W-1:0] chr,
  input  logic             mirror,
  input  logic [1:0]       size_sel,
  output logic [CHR_W-1:0] chr_bank,
  output logic             mirror_sel
);
  logic [CHR_W-1:0] mask;
  assign mask = chr_mask(size_sel);
  for (genvar g = 0; g < CHR_W; g++) begin : g_bit
    assign chr_bank[g] = chr[g] & mask[g];
  end
  assign mirror_sel = mirror;
endmodule

// File: rtl/bank_latch_mapper.sv
module bank_latch_mapper
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [7:0]        prg_rdata,
  input  logic              flash_save_en,
  input  logic [1:0]        chr_size_sel,
  output logic [18:0]       prg_addr,
  output logic [1:0]        chr_bank,
  output logic              mirror_sel,
  output logic              flash_cmd_we,
  output logic [14:0]       flash_cmd_addr,
  output logic [7:0]        flash_cmd_data
);
  latch_t latch_q, next_val;
  logic   load_event, flash_event;

  write_decode u_dec (
    .cpu_wr(cpu_wr), .addr_hi(cpu_addr[15:14]), .wdata(cpu_wdata),
    .rdata(prg_rdata), .flash_save_en(flash_save_en),
    .load(load_event), .flash_we(flash_event), .next_val(next_val)
  );

  latch_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load(load_event), .d(next_val), .q(latch_q)
  );

  prg_decode u_prg (
    .bank(latch_q.bank), .addr(cpu_addr[OFS_W:0]), .prg_addr(prg_addr)
  );

  chr_mirror u_chr (
    .chr(latch_q.chr), .mirror(latch_q.mirror), .size_sel(chr_size_sel),
    .chr_bank(chr_bank), .mirror_sel(mirror_sel)
  );

  assign flash_cmd_we   = flash_event;
  assign flash_cmd_addr = {latch_q.bank[0], cpu_addr[OFS_W-1:0]};
  assign flash_cmd_data = cpu_wdata;
endmodule

// File: rtl/bank_latch_mapper_chk.sv
module bank_latch_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [7:0]  prg_rdata,
  input logic        flash_save_en,
  input logic [18:0] prg_addr,
  input logic        mirror_sel,
  input logic        flash_cmd_we,
  input logic [7:0]  latch_q,
  input logic        load_event,
  input logic        flash_event
);
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> latch_q == 8'h00);
  assert_lower_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:14] == 2'b10 |-> prg_addr == {latch_q[4:0], cpu_addr[13:0]});
  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14] |-> prg_addr[18:14] == 5'h1F);
  assert_mirror_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_sel == latch_q[7]);
  assert_conflict_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_event && !flash_save_en) |=> latch_q == $past(cpu_wdata & prg_rdata));
  assert_plain_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_event && flash_save_en) |=> latch_q == $past(cpu_wdata));
  assert_flash_keeps_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flash_event |=> $stable(latch_q));
  assert_low_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |=> $stable(latch_q));
  assert_low_write_no_flash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |-> !flash_cmd_we);
  assert_flash_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_save_en || !cpu_wr) |-> !flash_cmd_we);
endmodule

bind bank_latch_mapper bank_latch_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .prg_rdata(prg_rdata), .flash_save_en(flash_save_en),
  .prg_addr(prg_addr), .mirror_sel(mirror_sel), .flash_cmd_we(flash_cmd_we),
  .latch_q(latch_q), .load_event(load_event), .flash_event(flash_event)
);

// File: tb/bank_latch_mapper_test.sv
module bank_latch_mapper_test;
  logic        clk = 0, rst_n = 0, cpu_wr = 0, flash_save_en = 0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 0, prg_rdata = 0;
  logic [1:0]  chr_size_sel = 2'd3;
  logic [18:0] prg_addr;
  logic [1:0]  chr_bank;
  logic        mirror_sel, flash_cmd_we;
  logic [14:0] flash_cmd_addr;
  logic [7:0]  flash_cmd_data;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] model = 8'h00;

  bank_latch_mapper uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_chr(input logic [7:0] r, input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'b00;
      2'd1:    return {1'b0, r[5]};
      default: return r[6:5];
    endcase
  endfunction

  // full register seen through the outputs, then window and field checks
  task automatic probe(input string req);
    logic [13:0] ofs = 14'($urandom);
    logic [1:0] sel = 2'($urandom);
    cpu_wr = 0;
    chr_size_sel = 2'd3; cpu_addr = {2'b10, ofs}; #1;
    chk({mirror_sel, chr_bank, prg_addr[18:14]} == model, req,
        {mirror_sel, chr_bank, prg_addr[18:14]}, model);
    chk(prg_addr == {model[4:0], ofs}, "R2", prg_addr, {model[4:0], ofs});
    cpu_addr = {2'b11, ofs}; #1;
    chk(prg_addr == {5'h1F, ofs}, "R3", prg_addr, {5'h1F, ofs});
    chr_size_sel = sel; #1;
    chk(chr_bank == exp_chr(model, sel), "R4", chr_bank, exp_chr(model, sel));
    chk(mirror_sel == model[7], "R5", mirror_sel, model[7]);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
    string req;
    bit exp_we;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; prg_rdata = r; cpu_wr = 1; #1;
    exp_we = flash_save_en && a[15:14] == 2'b10;
    if (!a[15]) req = "R9";
    else if (!flash_save_en) req = "R6";
    else if (a[14]) req = "R7";
    else req = "R8";
    chk(flash_cmd_we == exp_we, flash_save_en ? req : "R10", flash_cmd_we, exp_we);
    if (exp_we) begin
      chk(flash_cmd_addr == {model[0], a[13:0]}, "R8", flash_cmd_addr, {model[0], a[13:0]});
      chk(flash_cmd_data == d, "R8", flash_cmd_data, d);
    end
    @(posedge clk);
    if (a[15]) begin
      if (!flash_save_en) model = d & r;
      else if (a[14]) model = d;
    end
    @(negedge clk);
    cpu_wr = 0;
    probe(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5417));
    repeat (3) @(negedge clk);
    #1;
    chk({mirror_sel, chr_bank, prg_addr[18:14]} == 8'h00, "R1",
        {mirror_sel, chr_bank, prg_addr[18:14]}, 0);
    rst_n = 1;
    @(negedge clk);
    probe("R1");

    // bus conflict AND, then zero from memory byte
    flash_save_en = 0;
    do_write(16'h8000, 8'hFF, 8'h3C);
    do_write(16'hFFFF, 8'hFF, 8'h00);
    do_write(16'hC001, 8'hE7, 8'hFF);
    // flash mode: fixed-half load ignores memory byte
    flash_save_en = 1;
    do_write(16'hC123, 8'hA5, 8'h00);
    // flash command write with bank bit 0 = 1
    do_write(16'h9555, 8'hAA, 8'h11);
    do_write(16'hAAAA, 8'h55, 8'hFF);
    // ignored low-half writes in both modes
    do_write(16'h1234, 8'h00, 8'hFF);
    flash_save_en = 0;
    do_write(16'h7FFF, 8'h5A, 8'hFF);
    // bank 31 selected in the switchable half
    do_write(16'hBFFF, 8'h9F, 8'hFF);
    do_write(16'h4000, 8'h00, 8'h00);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 15) == 0) flash_save_en = ~flash_save_en;
      do_write(16'($urandom), 8'($urandom), ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule